// File: doc/BRIEF.md
# Three-Mode Process Timer

A single timer cell for process-control sequencing. One boolean input `din` drives one boolean output `dout`. The output follows one of three delay behaviours picked by `mode_sel`. These are an on-delay, an off-delay hold and a fixed-width pulse, and all three share one preset counter. Time is measured in ticks: the counter advances only on clock cycles where `tick_en` is high, so one clock domain can serve slow time bases.

The mode and the preset are sampled only while the timer is idle. While a timing cycle or latched state is in progress, changes on those inputs wait until the block returns to idle. `busy` shows that the block has left idle. The reset is asynchronous and active-low. Its release is synchronised internally, so the block starts responding two clock edges after `rst_n` rises.

Top module: `proc_timer`

## Requirements
- R1: While reset is active, and after an asynchronous reset mid-operation, `dout` and `busy` are 0 regardless of `din`.
- R2: `mode_sel` encoding: 2'b00 disabled (`dout` stays 0, `busy` stays 0), 2'b01 on-delay, 2'b10 off-delay hold, 2'b11 pulse.
- R3: On-delay: after `din` is first sampled high, `dout` goes high once `preset` further tick-qualified clock edges have been counted with `din` still high, and stays high while `din` stays high.
- R4: On-delay: `dout` is 0 in any cycle where `din` is 0. If `din` drops before the count completes, no output is produced and the count is discarded.
- R5: Off-delay: `dout` is high in the same cycle that `din` is high, with no register delay.
- R6: Off-delay: after `din` falls, `dout` stays high through the falling cycle and until `preset` tick-qualified edges have been counted, then returns to 0.
- R7: Off-delay: if `din` returns high during the hold, `dout` stays high with no gap, and the next fall starts a fresh hold.
- R8: Pulse: a rising edge of `din` in idle starts a `dout` pulse that lasts exactly `preset` tick-qualified edges, whatever the length of `din`.
- R9: Pulse: rising edges during a pulse are ignored. `din` still held high when a pulse ends starts no new pulse.
- R10: The counter advances only on edges where `tick_en` is 1. Edges with `tick_en` low stretch the timing.
- R11: `preset` of 0 makes `dout` equal `din` in modes 01 and 10, gives no pulse in mode 11, and keeps `busy` at 0.
- R12: Changes on `mode_sel` and `preset` while `busy` is 1 have no effect. They take effect once the block is idle.
- R13: `busy` is 1 from the edge where timing, holding or latching starts until the edge where the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Time-base strobe; counter advances only when high |
| mode_sel | input | 2 | Behaviour select (see R2) |
| preset | input | CNT_W | Delay or pulse length in ticks |
| din | input | 1 | Boolean process input |
| dout | output | 1 | Timed boolean output |
| busy | output | 1 | Block is out of idle |

## Verification
Each mode is driven with an input held past the preset, an input dropped before it, and short repeated pulses. These patterns separate the on-delay drop, the off-delay cancel and the pulse behaviour that ignores retriggers. A sparse `tick_en` pattern shows whether the counter respects the time base rather than the clock. Zero presets in every mode, and changes to mode and preset while busy, expose any wrong sampling of the configuration. A reset in the middle of a pulse checks that the output clears at once.

// File: rtl/proc_timer_pkg.sv
`timescale 1ns/1ps
package proc_timer_pkg;

  typedef enum logic [1:0] {
    MD_OFF    = 2'b00,
    MD_ONDLY  = 2'b01,
    MD_OFFDLY = 2'b10,
    MD_PULSE  = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_TIME  = 2'b01,
    ST_LATCH = 2'b10
  } tmr_state_e;

endpackage

// File: rtl/proc_timer_rstsync.sv
`timescale 1ns/1ps
module proc_timer_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/proc_timer_cnt.sv
`timescale 1ns/1ps
module proc_timer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             clr,
  input  logic             adv,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [EXT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
    hit     = adv && (cnt_inc == {1'b0, limit});
    cnt_en  = clr || adv;
    cnt_d   = clr ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_ok)
    run |-> (cnt_q < limit));  // R10
  AST_CNT_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_ok)
    (!adv && !clr) |=> $stable(cnt_q));  // R10
endmodule

// File: rtl/proc_timer_fsm.sv
`timescale 1ns/1ps
module proc_timer_fsm
  import proc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             din,
  input  logic             tick_en,
  input  tmr_mode_e        mode_in,
  input  logic [CNT_W-1:0] preset_in,
  input  logic             hit,
  output tmr_state_e       state,
  output tmr_mode_e        eff_mode,
  output logic             eff_pre_zero,
  output logic [CNT_W-1:0] limit,
  output logic             cnt_clr,
  output logic             cnt_adv
);
  tmr_state_e       state_q, state_d;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] preset_q;
  logic             din_q;
  logic             din_rise;
  logic             cfg_en;
  logic             in_pre_zero;

  always_comb begin
    din_rise     = din && !din_q;
    cfg_en       = (state_q == ST_IDLE);
    in_pre_zero  = (preset_in == '0);
    eff_mode     = cfg_en ? mode_in : mode_q;
    eff_pre_zero = cfg_en ? in_pre_zero : (preset_q == '0);
    cnt_adv      = tick_en && (state_q == ST_TIME);
  end

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!in_pre_zero) begin
          case (mode_in)
            MD_ONDLY:  if (din)      begin state_d = ST_TIME; cnt_clr = 1'b1; end
            MD_OFFDLY: if (din)      state_d = ST_LATCH;
            MD_PULSE:  if (din_rise) begin state_d = ST_TIME; cnt_clr = 1'b1; end
            default:   state_d = ST_IDLE;
          endcase
        end
      end
      ST_TIME: begin
        case (mode_q)
          MD_ONDLY: begin
            if (!din)     state_d = ST_IDLE;
            else if (hit) state_d = ST_LATCH;
          end
          MD_OFFDLY: begin
            if (din)      state_d = ST_LATCH;
            else if (hit) state_d = ST_IDLE;
          end
          MD_PULSE: if (hit) state_d = ST_IDLE;
          default:  state_d = ST_IDLE;
        endcase
      end
      ST_LATCH: begin
        case (mode_q)
          MD_ONDLY:  if (!din) state_d = ST_IDLE;
          MD_OFFDLY: if (!din) begin state_d = ST_TIME; cnt_clr = 1'b1; end
          default:   state_d = ST_IDLE;
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q <= ST_IDLE;
      din_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      din_q   <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      mode_q   <= MD_OFF;
      preset_q <= '0;
    end else if (cfg_en) begin
      mode_q   <= mode_in;
      preset_q <= preset_in;
    end
  end

  assign state = state_q;
  assign limit = preset_q;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q != ST_IDLE) |=> ($stable(mode_q) && $stable(preset_q)));  // R12
  AST_ONDLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_LATCH && mode_q == MD_ONDLY && !din) |=> (state_q == ST_IDLE));  // R4
  AST_HOLD_ARM: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_LATCH && mode_q == MD_OFFDLY && !din) |=> (state_q == ST_TIME));  // R6
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_TIME && mode_q == MD_PULSE && !hit) |=> (state_q == ST_TIME));  // R9
  AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_IDLE && preset_in == '0) |=> (state_q == ST_IDLE));  // R11
endmodule

// File: rtl/proc_timer_out.sv
`timescale 1ns/1ps
module proc_timer_out
  import proc_timer_pkg::*;
(
  input  logic       rst_ok,
  input  logic       din,
  input  tmr_state_e state,
  input  tmr_mode_e  eff_mode,
  input  logic       eff_pre_zero,
  output logic       dout,
  output logic       busy
);
  logic raw;

  always_comb begin
    case (eff_mode)
      MD_ONDLY:  raw = din && ((state == ST_LATCH) || ((state == ST_IDLE) && eff_pre_zero));
      MD_OFFDLY: raw = din || (state != ST_IDLE);
      MD_PULSE:  raw = (state == ST_TIME);
      default:   raw = 1'b0;
    endcase
    dout = rst_ok && raw;
    busy = rst_ok && (state != ST_IDLE);
  end
endmodule

// File: rtl/proc_timer.sv
`timescale 1ns/1ps
module proc_timer
  import proc_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] preset,
  input  logic             din,
  output logic             dout,
  output logic             busy
);
  logic             rst_ok;
  tmr_state_e       state;
  tmr_mode_e        eff_mode;
  logic             eff_pre_zero;
  logic [CNT_W-1:0] limit;
  logic             cnt_clr;
  logic             cnt_adv;
  logic             hit;
  tmr_mode_e        mode_in;

  assign mode_in = tmr_mode_e'(mode_sel);

  proc_timer_rstsync #(.STAGES(SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  proc_timer_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_ok(rst_ok), .din(din), .tick_en(tick_en),
    .mode_in(mode_in), .preset_in(preset), .hit(hit),
    .state(state), .eff_mode(eff_mode), .eff_pre_zero(eff_pre_zero),
    .limit(limit), .cnt_clr(cnt_clr), .cnt_adv(cnt_adv)
  );

  proc_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_ok(rst_ok), .clr(cnt_clr), .adv(cnt_adv),
    .run(state == ST_TIME), .limit(limit), .hit(hit)
  );

  proc_timer_out u_out (
    .rst_ok(rst_ok), .din(din), .state(state), .eff_mode(eff_mode),
    .eff_pre_zero(eff_pre_zero), .dout(dout), .busy(busy)
  );

  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy && state == ST_TIME && eff_mode == MD_PULSE && !hit) |=> dout);  // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy && mode_in == MD_OFF) |=> !busy);  // R2
endmodule

// File: tb/proc_timer_test.sv
`timescale 1ns/1ps
module proc_timer_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tick_en;
  logic [1:0]       mode_sel;
  logic [CNT_W-1:0] preset;
  logic             din;
  logic             dout;
  logic             busy;

  int    nvec = 0;
  int    nfail = 0;
  string tag = "R1";
  int    md = 0;
  int    pr = 0;
  int    ph = 0;
  int    cnt = 0;
  int    mm = 0;
  int    mp = 0;
  bit    prev = 1'b0;

  always #2.5 clk = ~clk;

  proc_timer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .preset(preset), .din(din), .dout(dout), .busy(busy)
  );

  task automatic check(input bit ed, input bit eb);
    nvec++;
    if (dout !== ed || busy !== eb) begin
      nfail++;
      $display("FAIL %s: dout=%0b busy=%0b expected dout=%0b busy=%0b at %0t",
               tag, dout, busy, ed, eb, $time);
    end
  endtask

  task automatic step(input bit d, input bit t);
    int em;
    int ep;
    bit ed;
    @(negedge clk);
    din = d; tick_en = t; mode_sel = 2'(md); preset = CNT_W'(pr);
    #1;
    em = (ph == 0) ? md : mm;
    ep = (ph == 0) ? pr : mp;
    case (em)
      1: ed = d && (ph == 2 || (ph == 0 && ep == 0));
      2: ed = d || (ph != 0);
      3: ed = (ph == 1);
      default: ed = 1'b0;
    endcase
    check(ed, ph != 0);
    @(posedge clk);
    case (ph)
      0: begin
        mm = md; mp = pr;
        if (mp != 0) begin
          if (mm == 1 && d) begin ph = 1; cnt = 0; end
          else if (mm == 2 && d) ph = 2;
          else if (mm == 3 && d && !prev) begin ph = 1; cnt = 0; end
        end
      end
      1: begin
        if (mm == 1) begin
          if (!d) ph = 0;
          else if (t) begin cnt++; if (cnt == mp) ph = 2; end
        end else if (mm == 2) begin
          if (d) ph = 2;
          else if (t) begin cnt++; if (cnt == mp) ph = 0; end
        end else begin
          if (t) begin cnt++; if (cnt == mp) ph = 0; end
        end
      end
      default: begin
        if (mm == 1 && !d) ph = 0;
        else if (mm == 2 && !d) begin ph = 1; cnt = 0; end
      end
    endcase
    prev = d;
  endtask

  task automatic hold(input bit d, input bit t, input int n);
    for (int i = 0; i < n; i++) step(d, t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; din = 1'b1; mode_sel = 2'b01; preset = '0; tick_en = 1'b1;
    #1;
    tag = "R1";
    check(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; check(1'b0, 1'b0);
    end
    @(negedge clk);
    din = 1'b0; mode_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    ph = 0; cnt = 0; prev = 1'b0; md = 0; pr = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = 1'b0; tick_en = 1'b0; mode_sel = '0; preset = '0;
    do_reset();

    tag = "R2"; md = 0; pr = 3;
    hold(1, 1, 5); hold(0, 1, 2); hold(1, 1, 1); hold(0, 1, 2);

    tag = "R3"; md = 1; pr = 4;
    hold(1, 1, 8); hold(0, 1, 2);

    tag = "R4"; md = 1; pr = 5;
    hold(1, 1, 3); hold(0, 1, 3); hold(1, 1, 8); hold(0, 1, 2);

    tag = "R10"; md = 1; pr = 3;
    for (int i = 0; i < 10; i++) step(1, i[0]);
    hold(0, 1, 2);
    md = 3; pr = 3;
    step(1, 0);
    for (int i = 0; i < 9; i++) step(0, (i % 3) == 2);
    hold(0, 1, 2);

    tag = "R5"; md = 2; pr = 3;
    hold(0, 1, 1); hold(1, 1, 3);
    tag = "R6";
    hold(0, 1, 8);

    tag = "R7"; md = 2; pr = 4;
    hold(1, 1, 2); hold(0, 1, 2); hold(1, 1, 2); hold(0, 1, 8);

    tag = "R8"; md = 3; pr = 4;
    hold(1, 1, 1); hold(0, 1, 7); hold(1, 1, 10); hold(0, 1, 3);

    tag = "R9"; md = 3; pr = 6;
    hold(1, 1, 1); hold(0, 1, 1); hold(1, 1, 1); hold(0, 1, 1);
    hold(1, 1, 6); hold(0, 1, 4);

    tag = "R11"; pr = 0;
    md = 1; hold(1, 1, 3); hold(0, 1, 2);
    md = 2; hold(1, 1, 3); hold(0, 1, 2);
    md = 3; hold(1, 1, 3); hold(0, 1, 2);

    tag = "R12"; md = 1; pr = 6;
    hold(1, 1, 2);
    md = 3; pr = 2;
    hold(1, 1, 8); hold(0, 1, 1);
    hold(1, 1, 1); hold(0, 1, 4);

    tag = "R13"; md = 3; pr = 3;
    hold(1, 0, 1);
    for (int i = 0; i < 8; i++) step(0, i[0]);
    md = 2; pr = 2;
    hold(1, 0, 2); hold(0, 0, 3); hold(0, 1, 3);

    md = 3; pr = 20; tag = "R1";
    hold(1, 1, 1); hold(0, 1, 3);
    do_reset();
    tag = "R1"; md = 0; pr = 1;
    hold(0, 1, 2);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule